// File: doc/BRIEF.md
# Timestamped Capture Chunk Decoder

This block turns the packed contents of a logic-analyzer capture memory into a flat stream of samples, one sample per time step. Memory arrives as bytes over a valid/ready input. The bytes form 16-byte clusters. Each cluster carries a 16-bit timestamp and seven 16-bit event words. An event word holds one, two or four samples for every channel, with the channel bits interleaved.

The decoder first compares each cluster's timestamp with the previous one. If time was skipped, it repeats the most recent output sample to fill the hole. It then unpacks the seven events of the cluster in order and emits their samples through a valid/ready output. A two-bit configuration input selects how many samples each event carries. A synchronous clear starts a new readout.

The timestamp and last-sample history carry on from one 1024-byte chunk to the next, so a readout of many chunks comes out as a single continuous stream.

Top module: `ccd_decoder`

## Requirements
- R1: After reset, and in the cycle after `clear` is sampled high, `out_valid` is 0 and `in_ready` is 1. Any partially received cluster is discarded, and the next cluster is treated as the first of a readout.
- R2: A cluster is 16 consecutive accepted bytes. Bytes 0 and 1 are the timestamp, low byte first. Bytes 2+2j and 3+2j are event word j (j = 0..6), low byte first. Events are output in order j = 0 to 6.
- R3: `spe_sel` code 0 selects 1 sample per event, code 1 selects 2, and codes 2 and 3 select 4. Each event yields that many samples, with sample index k ascending from 0.
- R4: In sample k of an event, output bit l (channel l) equals event bit 2·l+k for l < 16 / samples-per-event. Output bit l is 0 when that index exceeds 15 and for every higher channel.
- R5: The timestamp difference is computed modulo 2^16. When it exceeds 7, the last output sample is emitted (difference − 7) × samples-per-event times before the cluster's own samples.
- R6: A timestamp difference of 0 to 7 produces no padding.
- R7: The first cluster after reset or clear produces no padding. Its timestamp becomes the reference for the next cluster.
- R8: The timestamp reference and the last output sample carry over across 64-cluster chunk boundaries. Nothing extra is inserted at a boundary.
- R9: While `out_valid` is high and `out_ready` is low, `out_sample` holds its value. `in_ready` is low whenever `out_valid` is high.

Note: `spe_sel` must stay unchanged while a cluster is being decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of a readout |
| spe_sel | input | 2 | Samples-per-event code |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder accepts a byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer accepts a sample |
| out_sample | output | 16 | Decoded sample, bit l = channel l |

## Verification
Timestamp corner cases are driven directly:
- A difference of exactly 7, a difference of 2, and a wrap from 0xFFFC to 0x0006. A decoder that padded on small differences, or that lost the wrap, would emit surplus or missing repeated samples, and every later sample would line up wrongly.
- A clear issued mid-cluster. A decoder that kept the byte count or the timestamp reference would misalign the following clusters or pad before the first of them.

De-interleaving is checked in all three sample-per-event modes with asymmetric event patterns. This catches swapped channel and sample indices and leaked upper bits.

A 66-cluster run with random output stalls, and a gap placed just after the 64th cluster, exposes state lost at chunk boundaries and data changing under back-pressure.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_LOAD = 2'd1,
    ST_PAD  = 2'd2,
    ST_EMIT = 2'd3
  } ccd_state_e;

  // log2 of samples per event from the configuration code
  function automatic logic [1:0] spe_log_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/ccd_cluster_fill.sv
module ccd_cluster_fill #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear,
  input  logic                          byte_fire,
  input  logic [7:0]                    byte_in,
  output logic                          last_byte,
  output logic [WORDS-1:0][WORD_W-1:0]  words
);

  localparam int NBYTES = WORDS * WORD_W / 8;
  localparam int CW     = $clog2(NBYTES);

  logic [CW-1:0]       cnt_q, cnt_d;
  logic [NBYTES*8-1:0] data_q;

  assign last_byte = byte_fire && (cnt_q == CW'(NBYTES - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)          cnt_d = '0;
    else if (last_byte) cnt_d = '0;
    else if (byte_fire) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // byte lanes: one write enable per lane
  always_ff @(posedge clk) begin
    for (int b = 0; b < NBYTES; b++) begin
      if (byte_fire && (cnt_q == CW'(b))) data_q[8*b +: 8] <= byte_in;
    end
  end

  // little-endian words: word 0 is the timestamp, words 1.. are events
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign words[w] = data_q[w*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/ccd_gap_calc.sv
module ccd_gap_calc #(
  parameter int TS_W   = 16,
  parameter int EVENTS = 7,
  parameter int PAD_W  = TS_W + 3
) (
  input  logic [TS_W-1:0]  ts_now,
  input  logic [TS_W-1:0]  ts_prev,
  input  logic             first,
  input  logic [1:0]       spe_log,
  output logic [PAD_W-1:0] pad_cnt
);

  logic [TS_W-1:0] diff;
  logic [TS_W-1:0] excess;

  assign diff   = ts_now - ts_prev;
  assign excess = diff - TS_W'(EVENTS);

  always_comb begin
    if (first || (diff <= TS_W'(EVENTS))) pad_cnt = '0;
    else                                   pad_cnt = PAD_W'(excess) << spe_log;
  end

endmodule

// File: rtl/ccd_event_unpack.sv
module ccd_event_unpack #(
  parameter int W = 16
) (
  input  logic [W-1:0] ev,
  input  logic [1:0]   k,
  input  logic [1:0]   spe_log,
  output logic [W-1:0] smp
);

  localparam int EXT_W = 2 * W + 4;
  localparam int IW    = $clog2(EXT_W);
  localparam int NW    = $clog2(W) + 1;

  logic [EXT_W-1:0] ext;
  logic [NW-1:0]    n_ch;

  assign ext  = {{(EXT_W - W){1'b0}}, ev};
  assign n_ch = NW'(W) >> spe_log;

  for (genvar l = 0; l < W; l++) begin : g_ch
    assign smp[l] = (n_ch > NW'(l)) ? ext[IW'(2 * l) + IW'(k)] : 1'b0;
  end

endmodule

// File: rtl/ccd_decoder.sv
module ccd_decoder #(
  parameter int W      = 16,
  parameter int TS_W   = 16,
  parameter int EVENTS = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [1:0]   spe_sel,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [7:0]   in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_sample
);
  import ccd_pkg::*;

  localparam int WORDS = EVENTS + 1;
  localparam int EIW   = $clog2(WORDS);
  localparam int PAD_W = TS_W + 3;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  ccd_state_e             st_q, st_d;
  logic [PAD_W-1:0]       pad_q, pad_d;
  logic [EIW-1:0]         ev_q, ev_d;
  logic [1:0]             k_q, k_d;
  logic [W-1:0]           last_q, last_d;
  logic [TS_W-1:0]        prev_q, prev_d;
  logic                   first_q, first_d;
  logic                   hist_en, ctr_en;

  logic                   byte_fire, out_fire, last_byte;
  logic [WORDS-1:0][W-1:0] words;
  logic [PAD_W-1:0]       gap;
  logic [W-1:0]           ev_smp;
  logic [1:0]             spe_log, k_top;

  assign spe_log   = spe_log_of(spe_sel);
  assign k_top     = 2'((3'd1 << spe_log) - 3'd1);
  assign in_ready  = rst_i_n && (st_q == ST_FILL);
  assign out_valid = (st_q == ST_PAD) || (st_q == ST_EMIT);
  assign byte_fire = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign out_sample = (st_q == ST_PAD) ? last_q : ev_smp;

  ccd_cluster_fill #(.WORD_W(W), .WORDS(WORDS)) u_fill (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clear     (clear),
    .byte_fire (byte_fire),
    .byte_in   (in_data),
    .last_byte (last_byte),
    .words     (words)
  );

  ccd_gap_calc #(.TS_W(TS_W), .EVENTS(EVENTS), .PAD_W(PAD_W)) u_gap (
    .ts_now  (words[0][TS_W-1:0]),
    .ts_prev (prev_q),
    .first   (first_q),
    .spe_log (spe_log),
    .pad_cnt (gap)
  );

  ccd_event_unpack #(.W(W)) u_unpack (
    .ev      (words[ev_q + EIW'(1)]),
    .k       (k_q),
    .spe_log (spe_log),
    .smp     (ev_smp)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    pad_d   = pad_q;
    ev_d    = ev_q;
    k_d     = k_q;
    last_d  = last_q;
    prev_d  = prev_q;
    first_d = first_q;
    case (st_q)
      ST_FILL: if (last_byte) st_d = ST_LOAD;
      ST_LOAD: begin
        pad_d   = gap;
        prev_d  = words[0][TS_W-1:0];
        first_d = 1'b0;
        st_d    = (gap != '0) ? ST_PAD : ST_EMIT;
      end
      ST_PAD: if (out_fire) begin
        pad_d = pad_q - PAD_W'(1);
        if (pad_q == PAD_W'(1)) st_d = ST_EMIT;
      end
      ST_EMIT: if (out_fire) begin
        last_d = ev_smp;
        if (k_q == k_top) begin
          k_d = 2'd0;
          if (ev_q == EIW'(EVENTS - 1)) begin
            ev_d = '0;
            st_d = ST_FILL;
          end else begin
            ev_d = ev_q + EIW'(1);
          end
        end else begin
          k_d = k_q + 2'd1;
        end
      end
      default: st_d = ST_FILL;
    endcase
    if (clear) begin
      st_d    = ST_FILL;
      pad_d   = '0;
      ev_d    = '0;
      k_d     = 2'd0;
      last_d  = '0;
      first_d = 1'b1;
    end
  end

  assign hist_en = clear || (st_q == ST_LOAD) || ((st_q == ST_EMIT) && out_fire);
  assign ctr_en  = clear || (st_q != ST_FILL) || last_byte;

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_FILL;
      pad_q   <= '0;
      ev_q    <= '0;
      k_q     <= 2'd0;
      last_q  <= '0;
      prev_q  <= '0;
      first_q <= 1'b1;
    end else begin
      if (ctr_en) begin
        st_q  <= st_d;
        pad_q <= pad_d;
        ev_q  <= ev_d;
        k_q   <= k_d;
      end
      if (hist_en) begin
        last_q  <= last_d;
        prev_q  <= prev_d;
        first_q <= first_d;
      end
    end
  end

endmodule

// File: rtl/ccd_decoder_chk.sv
module ccd_decoder_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic [1:0]   spe_sel,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_sample
);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear) |=> (out_valid && $stable(out_sample)));

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));

  a_r1_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!out_valid && in_ready));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sample[W-1:W/2] == '0));

  a_r4_four_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && spe_sel[1]) |-> (out_sample[W-1:W/4] == '0));

endmodule

bind ccd_decoder ccd_decoder_chk #(.W(W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .spe_sel    (spe_sel),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample)
);

// File: tb/test_ccd_decoder.sv
module test_ccd_decoder;

  logic        clk = 1'b0;
  logic        rst_n, clear, in_valid, out_ready;
  logic [1:0]  spe_sel;
  logic [7:0]  in_data;
  logic        in_ready, out_valid;
  logic [15:0] out_sample;

  always #4 clk = ~clk;

  ccd_decoder i_ccd_decoder (
    .clk(clk), .rst_n(rst_n), .clear(clear), .spe_sel(spe_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  int          n_chk = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag = "R1";
  int          spe = 1;
  logic [15:0] m_prev = '0, m_last = '0;
  bit          m_first = 1'b1;
  bit          bp = 1'b0;
  logic [15:0] lf = 16'hACE1;
  bit          done = 1'b0;

  always @(posedge clk) begin
    #2;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    out_ready = bp ? lf[0] : 1'b1;
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_chk++;
      if (in_ready) begin
        n_bad++;
        $display("FAIL R9: in_ready=%0b expected 0 while out_valid", in_ready);
      end
      if (out_ready) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL %s: unexpected sample %h, expected none", tag, out_sample);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (out_sample !== e) begin
            n_bad++;
            $display("FAIL %s: sample %h expected %h", tag, out_sample, e);
          end
        end
      end
    end
  end

  function automatic logic [15:0] ref_smp(input logic [15:0] ev, input int k);
    logic [15:0] s = '0;
    for (int l = 0; l < 16 / spe; l++) begin
      if (2 * l + k < 16) s[l] = ev[2 * l + k];
    end
    return s;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_cluster(input logic [15:0] ts, input logic [15:0] ev [7]);
    logic [15:0] d;
    d = ts - m_prev;
    if (!m_first) begin
      for (int n = 0; n < int'(d) * spe - 7 * spe; n++) exp_q.push_back(m_last);
    end
    m_first = 1'b0;
    m_prev  = ts;
    for (int j = 0; j < 7; j++) begin
      for (int k = 0; k < spe; k++) begin
        m_last = ref_smp(ev[j], k);
        exp_q.push_back(m_last);
      end
    end
    send_byte(ts[7:0]);
    send_byte(ts[15:8]);
    for (int j = 0; j < 7; j++) begin
      send_byte(ev[j][7:0]);
      send_byte(ev[j][15:8]);
    end
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0) && (t < 20000)) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    n_chk++;
    if ((exp_q.size() != 0) || out_valid) begin
      n_bad++;
      $display("FAIL %s: %0d samples missing, out_valid=%0b, expected 0 and 0",
               tag, exp_q.size(), out_valid);
    end
    exp_q.delete();
  endtask

  task automatic do_clear(input logic [1:0] sel);
    @(negedge clk);
    clear = 1'b1;
    spe_sel = sel;
    spe = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 2 : 4;
    @(negedge clk);
    clear = 1'b0;
    m_first = 1'b1;
    m_last  = '0;
    n_chk++;
    if (out_valid || !in_ready) begin
      n_bad++;
      $display("FAIL R1: after clear out_valid=%0b in_ready=%0b expected 0 1",
               out_valid, in_ready);
    end
  endtask

  task automatic t_reset();
    tag = "R1";
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: reset out_valid=%0b in_ready=%0b expected 0 1",
               out_valid, in_ready);
    end
  endtask

  task automatic t_basic();
    logic [15:0] ev [7];
    ev = '{16'h0001, 16'h8000, 16'hAAAA, 16'h5555, 16'h1234, 16'hFFFF, 16'h00F0};
    tag = "R2/R3/R4/R7";
    send_cluster(16'd100, ev);
    tag = "R6 diff 7";
    ev = '{16'h0F0F, 16'hF0F0, 16'h3C3C, 16'hC3C3, 16'h0101, 16'h8080, 16'h7FFE};
    send_cluster(16'd107, ev);
    tag = "R6 diff 2";
    send_cluster(16'd109, ev);
    drain();
  endtask

  task automatic t_gap();
    logic [15:0] ev [7];
    ev = '{16'h1111, 16'h2222, 16'h4444, 16'h8888, 16'h0003, 16'hC000, 16'h5A5A};
    tag = "R5 gap spe1";
    send_cluster(16'd125, ev);
    drain();
  endtask

  task automatic t_spe2();
    logic [15:0] ev [7];
    do_clear(2'd1);
    ev = '{16'h0002, 16'h0001, 16'hAAAA, 16'h5555, 16'h8001, 16'h1234, 16'hFEDC};
    tag = "R3/R4 spe2";
    send_cluster(16'd5000, ev);
    tag = "R5 gap spe2";
    send_cluster(16'd5010, ev);
    drain();
  endtask

  task automatic t_spe4_wrap();
    logic [15:0] ev [7];
    do_clear(2'd2);
    bp = 1'b1;
    ev = '{16'h0001, 16'h0002, 16'h0004, 16'h0008, 16'h03FF, 16'h0155, 16'hFFFF};
    tag = "R3/R4 spe4";
    send_cluster(16'hFFFC, ev);
    tag = "R5 wrap spe4";
    send_cluster(16'h0006, ev);
    drain();
    bp = 1'b0;
  endtask

  task automatic t_clear_mid();
    logic [15:0] ev [7];
    do_clear(2'd0);
    send_byte(8'h55);
    send_byte(8'h66);
    send_byte(8'h77);
    send_byte(8'h88);
    send_byte(8'h99);
    do_clear(2'd0);
    ev = '{16'h0102, 16'h0304, 16'h0506, 16'h0708, 16'h090A, 16'h0B0C, 16'h0D0E};
    tag = "R1/R7 after clear";
    send_cluster(16'h8000, ev);
    send_cluster(16'h8009, ev);
    drain();
  endtask

  task automatic t_chunks();
    logic [15:0] ev [7];
    logic [15:0] ts;
    do_clear(2'd0);
    bp = 1'b1;
    tag = "R8 chunk carry";
    ts = 16'd3000;
    for (int c = 0; c < 66; c++) begin
      for (int j = 0; j < 7; j++) ev[j] = 16'(c * 16'h0123 + j * 16'h1111 + 1);
      send_cluster(ts, ev);
      ts = ts + ((c == 63) ? 16'd9 : 16'd7);
    end
    drain();
    bp = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; clear = 1'b0; in_valid = 1'b0; in_data = '0;
    spe_sel = 2'd0; out_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_gap();
    t_spe2();
    t_spe4_wrap();
    t_clear_mid();
    t_chunks();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule